// File: doc/BRIEF.md
# Descriptor Ring Transmit DMA Channel

This block is one transmit DMA channel. It walks a circular chain of descriptors in memory and sends the packet buffer that each descriptor points to as a byte stream toward a switch port. Software writes the address of the first descriptor and then issues commands through a small register port. The engine reads each descriptor over a word-wide memory request port and checks its hold flag. If the flag is clear, it reads the buffer and sends the bytes. It then writes a completion flag back into the descriptor and follows the next-descriptor pointer.

A descriptor whose hold flag is set parks the channel. The engine reads the same descriptor again after a programmable polling interval, or at once when software issues a hold-release command. This lets software hand descriptors to the engine one at a time by moving the hold marker along the ring. Completion, end-of-packet and parked events set sticky status bits. An interrupt line is raised for any status bit whose mask bit is clear.

A descriptor is four 32-bit words on a 16-byte boundary:

| Byte offset | Contents |
|---|---|
| +0 | Control word |
| +4 | Next-descriptor pointer |
| +8 | Buffer pointer |
| +12 | Completion word |

Control word fields:

| Bits | Meaning |
|---|---|
| 31 | Hold |
| 30 | End of packet |
| 29 | Start of packet |
| 28 | Interrupt on completion |
| 27 | Interrupt on end of packet |
| 26:22 | Reserved |
| 21:0 | Byte count |

Top module: `txdma_channel`

## Requirements
- R1: When a control word (offset +0) is read with bit 31 (hold) set, the channel sends no data, writes nothing back, and later reads the control word of the same descriptor again.
- R2: After a descriptor completes, the next control read uses the next-descriptor pointer (offset +4, low 4 bits forced to zero). A chain whose last pointer leads back to the first wraps around. A packet may span several descriptors.
- R3: The buffer (pointer at offset +8, low 2 bits forced to zero) is sent as exactly the byte count (bits 21:0) of bytes. Byte 0 of a buffer word is bits 7:0, byte 1 is bits 15:8, and so on. The stream and the memory port are never active in the same cycle.
- R4: tx_sof is high only on the first byte of a descriptor that has bit 29 set. tx_last is high only on the final byte of a descriptor that has bit 30 set.
- R5: A descriptor with a byte count of zero produces no stream beats and is still completed.
- R6: Completion writes 32'h8000_0000 to offset +12 of the descriptor, after its last byte has been accepted.
- R7: Register 1 takes commands in bits 1:0. 0 stops the channel, 1 starts it at the first-descriptor address (register 0), 2 releases a parked channel so that it reads again on the next cycle. Code 3 is ignored. Reading register 1 returns 1 in bit 0 while the channel runs.
- R8: While parked, the control word is read again poll+1 cycles after the parking read is accepted, where poll is register 2 (reset value 7).
- R9: Register 4 holds sticky status. Bit 0 means a descriptor with bit 28 set completed. Bit 1 means a descriptor with bits 27 and 30 set completed. Bit 2 means the channel parked on hold. Writing a 1 to a status bit clears it. The mask in register 3 resets to 3'b111. irq is high when any status bit is set with its mask bit clear.
- R10: A memory request holds its address and direction until mem_ready. A stream beat holds its data and markers until tx_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 first, 1 command, 2 poll, 3 mask, 4 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request; read data is valid in the same cycle |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink accepts the byte |
| tx_data | output | 8 | Stream byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_last | output | 1 | Final byte of a frame |
| irq | output | 1 | Unmasked status pending |

## Verification
The checker watches every cycle for these properties:
- memory requests and stream beats stay stable while stalled;
- write-backs carry the completion word to offset +12;
- reads are word-aligned;
- the stream and memory port are never active together;
- writing an all-ones mask drops irq.

Only the bench scenarios can show the rest:
- the byte order and byte count across a sweep of buffer lengths;
- the frame markers for packets that span descriptors;
- the exact polling interval;
- the immediate re-read after a release;
- the wrap-around when the hold marker moves along the ring;
- the effect of each command.

// File: rtl/txdma_pkg.sv
`timescale 1ns/1ps
package txdma_pkg;
    typedef enum logic [2:0] {
        S_OFF, S_RD_CTL, S_RD_NXT, S_RD_PTR, S_RD_BUF, S_SEND, S_PARK, S_WB
    } eng_state_t;

    typedef struct packed {
        logic        hold;
        logic        eop;
        logic        sop;
        logic        irq_done;
        logic        irq_eop;
        logic [4:0]  rsvd;
        logic [21:0] nbytes;
    } desc_ctl_t;

    typedef enum logic [1:0] {CMD_OFF = 2'd0, CMD_INIT = 2'd1, CMD_RELEASE = 2'd2} chan_cmd_t;

    localparam logic [2:0] RA_FIRST = 3'd0;
    localparam logic [2:0] RA_CMD   = 3'd1;
    localparam logic [2:0] RA_POLL  = 3'd2;
    localparam logic [2:0] RA_MASK  = 3'd3;
    localparam logic [2:0] RA_STAT  = 3'd4;

    localparam int NUM_SRC = 3;
    localparam int ST_DONE = 0;
    localparam int ST_EOP  = 1;
    localparam int ST_PARK = 2;

    localparam logic [31:0] DONE_WORD = 32'h8000_0000;

    function automatic desc_ctl_t to_ctl(input logic [31:0] w);
        return desc_ctl_t'(w);
    endfunction
endpackage

// File: rtl/txdma_poll_timer.sv
`timescale 1ns/1ps
module txdma_poll_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= '0;
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/txdma_regs.sv
`timescale 1ns/1ps
module txdma_regs
    import txdma_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int POLL_W   = 8,
    parameter int POLL_RST = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              active,
    input  logic [NUM_SRC-1:0] events,
    output logic [ADDR_W-1:0] first_addr,
    output logic [POLL_W-1:0] poll_time,
    output logic              cmd_off,
    output logic              cmd_init,
    output logic              cmd_release,
    output logic              irq
);
    logic [NUM_SRC-1:0] mask_q, stat_q, clr;
    logic               wr_cmd;

    assign wr_cmd      = reg_we && reg_addr == RA_CMD;
    assign cmd_off     = wr_cmd && reg_wdata[1:0] == CMD_OFF;
    assign cmd_init    = wr_cmd && reg_wdata[1:0] == CMD_INIT;
    assign cmd_release = wr_cmd && reg_wdata[1:0] == CMD_RELEASE;
    assign clr         = (reg_we && reg_addr == RA_STAT) ? reg_wdata[NUM_SRC-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_addr <= '0;
            poll_time  <= POLL_W'(POLL_RST);
            mask_q     <= '1;
            stat_q     <= '0;
        end else begin
            if (reg_we && reg_addr == RA_FIRST) first_addr <= {reg_wdata[ADDR_W-1:4], 4'b0};
            if (reg_we && reg_addr == RA_POLL)  poll_time  <= reg_wdata[POLL_W-1:0];
            if (reg_we && reg_addr == RA_MASK)  mask_q     <= reg_wdata[NUM_SRC-1:0];
            stat_q <= (stat_q & ~clr) | events;
        end
    end

    always_comb begin
        case (reg_addr)
            RA_FIRST: reg_rdata = 32'(first_addr);
            RA_CMD:   reg_rdata = {31'b0, active};
            RA_POLL:  reg_rdata = 32'(poll_time);
            RA_MASK:  reg_rdata = 32'(mask_q);
            RA_STAT:  reg_rdata = 32'(stat_q);
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = |(stat_q & ~mask_q);
endmodule

// File: rtl/txdma_engine.sv
`timescale 1ns/1ps
module txdma_engine
    import txdma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic              cmd_off,
    input  logic              cmd_init,
    input  logic              cmd_release,
    input  logic              poll_expired,
    output logic              poll_load,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_sof,
    output logic              tx_last,
    output logic [NUM_SRC-1:0] events,
    output logic              active
);
    eng_state_t        st_q;
    desc_ctl_t         ctl_q, rd_ctl;
    logic [ADDR_W-1:0] cur_q, nxt_q, buf_q;
    logic [21:0]       left_q;
    logic [31:0]       word_q;
    logic [1:0]        lane_q;
    logic              first_q, acc;

    assign rd_ctl    = to_ctl(mem_rdata);
    assign acc       = mem_req && mem_ready;
    assign poll_load = (st_q == S_RD_CTL) && acc && rd_ctl.hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_OFF;
            ctl_q   <= '0;
            cur_q   <= '0;
            nxt_q   <= '0;
            buf_q   <= '0;
            left_q  <= '0;
            word_q  <= '0;
            lane_q  <= '0;
            first_q <= 1'b0;
        end else if (cmd_off) begin
            st_q <= S_OFF;
        end else if (cmd_init) begin
            st_q  <= S_RD_CTL;
            cur_q <= first_addr;
        end else begin
            case (st_q)
                S_RD_CTL: if (acc) begin
                    ctl_q <= rd_ctl;
                    st_q  <= rd_ctl.hold ? S_PARK : S_RD_NXT;
                end
                S_PARK: if (cmd_release || poll_expired) st_q <= S_RD_CTL;
                S_RD_NXT: if (acc) begin
                    nxt_q <= {mem_rdata[ADDR_W-1:4], 4'b0};
                    st_q  <= S_RD_PTR;
                end
                S_RD_PTR: if (acc) begin
                    buf_q   <= {mem_rdata[ADDR_W-1:2], 2'b0};
                    left_q  <= ctl_q.nbytes;
                    first_q <= 1'b1;
                    st_q    <= (ctl_q.nbytes == '0) ? S_WB : S_RD_BUF;
                end
                S_RD_BUF: if (acc) begin
                    word_q <= mem_rdata;
                    lane_q <= '0;
                    buf_q  <= buf_q + ADDR_W'(4);
                    st_q   <= S_SEND;
                end
                S_SEND: if (tx_ready) begin
                    left_q  <= left_q - 1'b1;
                    lane_q  <= lane_q + 1'b1;
                    first_q <= 1'b0;
                    if (left_q == 22'd1)      st_q <= S_WB;
                    else if (lane_q == 2'd3)  st_q <= S_RD_BUF;
                end
                S_WB: if (acc) begin
                    cur_q <= nxt_q;
                    st_q  <= S_RD_CTL;
                end
                default: st_q <= S_OFF;
            endcase
        end
    end

    always_comb begin
        mem_req  = 1'b1;
        mem_we   = 1'b0;
        mem_addr = cur_q;
        case (st_q)
            S_RD_CTL: mem_addr = cur_q;
            S_RD_NXT: mem_addr = cur_q + ADDR_W'(4);
            S_RD_PTR: mem_addr = cur_q + ADDR_W'(8);
            S_RD_BUF: mem_addr = buf_q;
            S_WB: begin
                mem_addr = cur_q + ADDR_W'(12);
                mem_we   = 1'b1;
            end
            default:  mem_req = 1'b0;
        endcase
    end

    assign mem_wdata = DONE_WORD;
    assign tx_valid  = (st_q == S_SEND);
    assign tx_data   = word_q[{lane_q, 3'b0} +: 8];
    assign tx_sof    = tx_valid && ctl_q.sop && first_q;
    assign tx_last   = tx_valid && ctl_q.eop && (left_q == 22'd1);
    assign active    = (st_q != S_OFF);

    always_comb begin
        events          = '0;
        events[ST_DONE] = (st_q == S_WB) && acc && ctl_q.irq_done;
        events[ST_EOP]  = (st_q == S_WB) && acc && ctl_q.irq_eop && ctl_q.eop;
        events[ST_PARK] = poll_load;
    end
endmodule

// File: rtl/txdma_channel.sv
`timescale 1ns/1ps
module txdma_channel
    import txdma_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int POLL_W   = 8,
    parameter int POLL_RST = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_sof,
    output logic              tx_last,
    output logic              irq
);
    logic [ADDR_W-1:0]  first_addr;
    logic [POLL_W-1:0]  poll_time;
    logic               cmd_off, cmd_init, cmd_release, active;
    logic               poll_load, poll_expired;
    logic [NUM_SRC-1:0] events;

    txdma_regs #(.ADDR_W(ADDR_W), .POLL_W(POLL_W), .POLL_RST(POLL_RST)) u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .active(active),
        .events(events), .first_addr(first_addr), .poll_time(poll_time),
        .cmd_off(cmd_off), .cmd_init(cmd_init), .cmd_release(cmd_release),
        .irq(irq)
    );

    txdma_poll_timer #(.W(POLL_W)) u_timer (
        .clk(clk), .rst(rst), .load(poll_load), .load_val(poll_time),
        .expired(poll_expired)
    );

    txdma_engine #(.ADDR_W(ADDR_W)) u_eng (
        .clk(clk), .rst(rst), .first_addr(first_addr), .cmd_off(cmd_off),
        .cmd_init(cmd_init), .cmd_release(cmd_release),
        .poll_expired(poll_expired), .poll_load(poll_load),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_sof(tx_sof), .tx_last(tx_last), .events(events), .active(active)
    );
endmodule

// File: rtl/txdma_checker.sv
`timescale 1ns/1ps
module txdma_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [2:0]        reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_ready,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic [7:0]        tx_data,
    input logic              tx_sof,
    input logic              tx_last,
    input logic              irq
);
    assert_mem_hold_R10: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    assert_tx_hold_R10: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_last));

    assert_wb_word_R6: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> mem_wdata == 32'h8000_0000 && mem_addr[3:0] == 4'hC);

    assert_read_aligned_R3: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_we |-> mem_addr[1:0] == 2'b00);

    assert_port_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(tx_valid && mem_req));

    assert_mask_all_R9: assert property (@(posedge clk) disable iff (rst)
        reg_we && reg_addr == 3'd3 && reg_wdata[2:0] == 3'b111 |=> !irq);
endmodule

bind txdma_channel txdma_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_sof(tx_sof), .tx_last(tx_last), .irq(irq)
);

// File: tb/sim_txdma_channel.sv
`timescale 1ns/1ps
module sim_txdma_channel;
    localparam logic [31:0] F_HOLD = 32'h8000_0000;
    localparam logic [31:0] F_EOP  = 32'h4000_0000;
    localparam logic [31:0] F_SOP  = 32'h2000_0000;
    localparam logic [31:0] F_ICPT = 32'h1000_0000;
    localparam logic [31:0] F_IEOP = 32'h0800_0000;

    logic        clk = 1'b0, rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        tx_valid, tx_ready, tx_sof, tx_last, irq;
    logic [7:0]  tx_data;

    logic [31:0] mem [0:63];
    int          cyc = 0, total = 0, bad = 0, ncap = 0;
    logic        stall = 1'b0, done = 1'b0;
    logic [7:0]  cap_d [0:63];
    logic        cap_s [0:63];
    logic        cap_l [0:63];

    always #2.5 clk = ~clk;

    assign tx_ready  = stall ? (cyc[0] | cyc[2]) : 1'b1;
    assign mem_ready = mem_req & (stall ? (cyc[1] | ~cyc[0]) : 1'b1);
    assign mem_rdata = mem[mem_addr[7:2]];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && mem_ready && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
        if (tx_valid && tx_ready && ncap < 64) begin
            cap_d[ncap] <= tx_data;
            cap_s[ncap] <= tx_sof;
            cap_l[ncap] <= tx_last;
            ncap <= ncap + 1;
        end
        if (cyc > 150000 && !done) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    txdma_channel u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .tx_data(tx_data), .tx_sof(tx_sof),
        .tx_last(tx_last), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [7:0] bval(input int seed, input int k);
        return 8'(seed + 3 * k);
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem[i] = '0;
    endtask

    task automatic fill_buf(input int wbase, input int n, input int seed);
        for (int k = 0; k < n; k++) mem[wbase + k / 4][8 * (k % 4) +: 8] = bval(seed, k);
    endtask

    task automatic set_desc(input int w, input logic [31:0] ctl, input logic [31:0] nx, input logic [31:0] bp);
        mem[w] = ctl; mem[w + 1] = nx; mem[w + 2] = bp; mem[w + 3] = '0;
    endtask

    task automatic start();
        ncap = 0;
        wr(3'd4, 32'h7);
        wr(3'd1, 32'h1);
    endtask

    task automatic wait_park();
        logic [31:0] s;
        int n = 0;
        s = '0;
        while (!s[2] && n < 4000) begin
            rd(3'd4, s);
            n++;
        end
        check(s[2] == 1'b1, "R1 park reached", s, 4);
    endtask

    task automatic run_len(input int len, input int seed);
        logic [31:0] s;
        clear_mem();
        set_desc(0, F_SOP | F_EOP | F_ICPT | 32'(len), 32'h10, 32'h40);
        set_desc(4, F_HOLD, 32'h0, 32'h0);
        fill_buf(16, len, seed);
        start();
        wait_park();
        wr(3'd1, 32'h0);
        check(ncap == len, "R3 byte count", ncap, len);
        for (int k = 0; k < len; k++) begin
            check(cap_d[k] == bval(seed, k), stall ? "R10 byte under stall" : "R3 byte order", cap_d[k], bval(seed, k));
            check(cap_s[k] == (k == 0), "R4 sof", cap_s[k], k == 0);
            check(cap_l[k] == (k == len - 1), "R4 last", cap_l[k], k == len - 1);
        end
        check(mem[3] == 32'h8000_0000, "R6 completion word", mem[3], 32'h8000_0000);
        check(mem[7] == 32'h0, "R1 held descriptor untouched", mem[7], 0);
        rd(3'd4, s);
        check(s[1:0] == 2'b01, "R9 status after icpt packet", s[1:0], 1);
    endtask

    task automatic gap_test(input int poll);
        int g = 0;
        clear_mem();
        set_desc(0, F_HOLD, 32'h0, 32'h0);
        wr(3'd2, 32'(poll));
        start();
        @(negedge clk);
        while (!mem_req && g < 1000) begin @(negedge clk); g++; end
        g = 0;
        while (mem_req) @(negedge clk);
        while (!mem_req && g < 1000) begin @(negedge clk); g++; end
        check(g == poll + 1, "R8 poll interval", g, poll + 1);
        check(mem_addr == 32'h0 && !mem_we, "R1 same descriptor re-read", mem_addr, 0);
        wr(3'd1, 32'h0);
    endtask

    initial begin
        logic [31:0] s;
        clear_mem();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!tx_valid && !mem_req && !irq, "R7 idle after reset", {tx_valid, mem_req, irq}, 0);
        rd(3'd3, s); check(s == 32'h7, "R9 mask reset", s, 7);
        rd(3'd2, s); check(s == 32'h7, "R8 poll reset", s, 7);
        rd(3'd4, s); check(s == 32'h0, "R9 status reset", s, 0);
        rd(3'd1, s); check(s == 32'h0, "R7 inactive after reset", s, 0);

        for (int len = 1; len <= 9; len++) begin
            stall = (len % 2 == 1) && len > 2;
            run_len(len, len * 17);
        end
        stall = 1'b0;

        clear_mem();
        set_desc(0, F_SOP | 32'd3, 32'h10, 32'h40);
        set_desc(4, F_EOP | F_IEOP | 32'd2, 32'h20, 32'h80);
        set_desc(8, F_HOLD, 32'h0, 32'h0);
        fill_buf(16, 3, 5);
        fill_buf(32, 2, 90);
        start();
        wait_park();
        wr(3'd1, 32'h0);
        check(ncap == 5, "R2 multi-descriptor count", ncap, 5);
        for (int k = 0; k < 5; k++) begin
            logic [7:0] e;
            e = (k < 3) ? bval(5, k) : bval(90, k - 3);
            check(cap_d[k] == e, "R2 chain data", cap_d[k], e);
            check(cap_s[k] == (k == 0) && cap_l[k] == (k == 4), "R4 markers across descriptors", {cap_s[k], cap_l[k]}, {k == 0, k == 4});
        end
        rd(3'd4, s);
        check(s[1:0] == 2'b10, "R9 eop status only", s[1:0], 2);

        clear_mem();
        set_desc(0, F_SOP | F_EOP | F_ICPT | F_IEOP, 32'h10, 32'h40);
        set_desc(4, F_HOLD, 32'h0, 32'h0);
        start();
        wait_park();
        check(ncap == 0, "R5 zero count no beats", ncap, 0);
        check(mem[3] == 32'h8000_0000, "R5 zero count completed", mem[3], 32'h8000_0000);
        rd(3'd4, s); check(s == 32'h7, "R9 all status set", s, 7);
        rd(3'd1, s); check(s == 32'h1, "R7 active while parked", s, 1);
        check(!irq, "R9 masked irq low", irq, 0);
        wr(3'd3, 32'h6);
        @(negedge clk); check(irq, "R9 unmasked irq", irq, 1);
        wr(3'd4, 32'h1);
        @(negedge clk); check(!irq, "R9 clear by writing one", irq, 0);
        rd(3'd4, s); check(s == 32'h6, "R9 other bits kept", s, 6);
        wr(3'd3, 32'h7);
        wr(3'd1, 32'h3);
        rd(3'd1, s); check(s == 32'h1, "R7 code 3 ignored", s, 1);
        wr(3'd1, 32'h0);
        rd(3'd1, s); check(s == 32'h0, "R7 off command", s, 0);
        begin
            int reqs = 0;
            for (int i = 0; i < 20; i++) begin @(negedge clk); if (mem_req) reqs++; end
            check(reqs == 0, "R7 no requests when off", reqs, 0);
        end

        gap_test(7);
        gap_test(2);
        gap_test(0);

        clear_mem();
        set_desc(0, F_HOLD, 32'h10, 32'h40);
        set_desc(4, F_HOLD, 32'h0, 32'h0);
        fill_buf(16, 2, 40);
        wr(3'd2, 32'd200);
        start();
        repeat (12) @(negedge clk);
        mem[0] = F_SOP | F_EOP | 32'd2;
        wr(3'd1, 32'h2);
        check(mem_req && mem_addr == 32'h0, "R7 release re-reads at once", {mem_req, mem_addr[7:0]}, {1'b1, 8'h00});
        wr(3'd4, 32'h7);
        wait_park();
        check(ncap == 2 && cap_d[1] == bval(40, 1), "R7 packet after release", ncap, 2);

        mem[0] = F_HOLD;
        mem[4] = F_SOP | F_EOP | F_ICPT | 32'd3;
        mem[6] = 32'h80;
        fill_buf(32, 3, 200);
        wr(3'd4, 32'h7);
        wr(3'd1, 32'h2);
        wait_park();
        check(ncap == 5, "R2 moved hold marker count", ncap, 5);
        check(cap_d[4] == bval(200, 2), "R2 second buffer data", cap_d[4], bval(200, 2));
        check(mem[7] == 32'h8000_0000, "R6 second descriptor completed", mem[7], 32'h8000_0000);
        check(mem[3] == 32'h8000_0000 && mem[0] == F_HOLD, "R2 wrap parks on first", mem[0], F_HOLD);
        wr(3'd1, 32'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule